// File: doc/BRIEF.md
# Masked SIMD Processing Element Array

A control stage receives one decoded compute instruction and broadcasts it to four processing elements (PEs). Each PE has four 16-bit general registers, a private 16-word by 16-bit local memory and its own flag set (overflow, carry, zero, sign). A 4-bit mask travels with every instruction. Only the PEs whose mask bit is set carry the instruction out. The other PEs keep their registers, memory and flags exactly as they were.

An instruction is a 6-bit opcode, a destination register index, a 4-bit operand address and the PE mask, presented together with a one-cycle `start_i` strobe. The opcode's top two bits give the instruction class, bit 3 selects immediate or direct operand mode, and bits 2:0 give the operation. The control stage registers the instruction on the edge where `start_i` is high. All enabled PEs commit on the following edge. `done_o` is high for the one cycle after that commit. Three read-select ports make every register, memory word and flag set observable.

Top module: `simd_pe_array`

## Requirements
- R1: The array changes no register, memory word or flag for an instruction whose class field (opcode bits 5:4) is not 00. `done_o` still pulses for that instruction.
- R2: A PE whose mask bit (`mask_i[p]` for PE p) is clear keeps its registers, memory and flags unchanged for that instruction.
- R3: LOAD (opcode bits 2:0 = 0) writes the operand into the destination register. It sets zero and sign from the loaded value and clears carry and overflow.
- R4: STORE (op = 1) in direct mode writes the destination register to memory word `addr_i`. It does not change the flags.
- R5: ADD (op = 2) writes the low 16 bits of register plus operand to the destination register. Carry is bit 16 of the unsigned sum. Overflow is set when both inputs have the same sign and the result's sign differs. Zero and sign come from the 16-bit result.
- R6: MULTIPLY (op = 3) writes the low 16 bits of the product to the destination register. Carry is set when the upper 16 bits of the unsigned product are nonzero. Overflow is set when the signed product lies outside -32768..32767. Zero and sign come from the truncated result.
- R7: With opcode bit 3 set (immediate mode), the operand is `addr_i` zero-extended to 16 bits instead of memory word `addr_i`. A STORE in immediate mode writes nothing and changes nothing.
- R8: `done_o` is high exactly in the cycle after the commit edge, which is two edges after the edge that sampled `start_i`. Every enabled PE's result is visible in that same cycle.
- R9: After reset all registers, memory words and flags read zero and `done_o` is low.
- R10: Operation codes 4 to 7 change no state.
- R11: `flags_o[4p+3:4p]` holds PE p's flags as {overflow, carry, zero, sign}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Instruction valid strobe |
| opcode_i | input | 6 | {class[1:0], immediate, op[2:0]} |
| dst_i | input | 2 | Destination register index |
| addr_i | input | 4 | Memory address or immediate value |
| mask_i | input | 4 | Per-PE enable mask |
| done_o | output | 1 | One-cycle completion pulse |
| obs_pe_i | input | 2 | PE selected for observation |
| obs_reg_i | input | 2 | Register selected for observation |
| obs_addr_i | input | 4 | Memory word selected for observation |
| obs_reg_o | output | 16 | Selected register value |
| obs_mem_o | output | 16 | Selected memory word |
| flags_o | output | 16 | Flags of all PEs, 4 bits per PE |

## Verification
Four properties are checked on every cycle:
- a PE that is not enabled keeps its register file, memory and flags stable across the commit edge;
- `done_o` is only ever high two edges after a sampled start;
- an instruction of a non-compute class leaves every flag unchanged;
- the zero flag after an ADD into register 0 agrees with that register.

Only the bench's scenarios can show that the arithmetic is correct: the ADD and MULTIPLY results and their carry and overflow edge cases under varied masks, operand modes and register choices. The bench compares these against its own arithmetic model.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int CLS_W = 2;
  localparam int OP_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LD  = 3'd0,
    OP_ST  = 3'd1,
    OP_ADD = 3'd2,
    OP_MUL = 3'd3
  } op_e;

  typedef struct packed {
    logic ovf;
    logic cry;
    logic zer;
    logic sgn;
  } flags_t;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int REG_AW = 2,
  parameter int MEM_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [5:0]        opcode_i,
  input  logic [REG_AW-1:0] dst_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [NUM_PE-1:0] mask_i,
  output logic [NUM_PE-1:0] pe_en_o,
  output logic [OP_W-1:0]   op_o,
  output logic              imm_o,
  output logic [REG_AW-1:0] dst_o,
  output logic [MEM_AW-1:0] addr_o,
  output logic              done_o
);
  logic              vld_q;
  logic [5:0]        opc_q;
  logic [REG_AW-1:0] dst_q;
  logic [MEM_AW-1:0] addr_q;
  logic [NUM_PE-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      opc_q  <= '0;
      dst_q  <= '0;
      addr_q <= '0;
      mask_q <= '0;
      done_o <= 1'b0;
    end else begin
      vld_q  <= start_i;
      done_o <= vld_q;
      if (start_i) begin
        opc_q  <= opcode_i;
        dst_q  <= dst_i;
        addr_q <= addr_i;
        mask_q <= mask_i;
      end
    end
  end

  // only class 00 reaches the PEs
  assign pe_en_o = (vld_q && opc_q[5:4] == 2'b00) ? mask_q : '0;
  assign op_o    = opc_q[OP_W-1:0];
  assign imm_o   = opc_q[3];
  assign dst_o   = dst_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic              imm_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  flags_t            flg_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flg_o,
  output logic              wr_reg_o,
  output logic              wr_mem_o
);
  localparam int PW = 2 * DATA_W;

  logic [DATA_W:0]        sum;
  logic [PW-1:0]          prod_u;
  logic signed [PW-1:0]   prod_s;
  logic [DATA_W:0]        prod_hi;

  assign sum     = {1'b0, a_i} + {1'b0, b_i};
  assign prod_u  = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
  assign prod_s  = $signed({{DATA_W{a_i[DATA_W-1]}}, a_i}) * $signed({{DATA_W{b_i[DATA_W-1]}}, b_i});
  assign prod_hi = prod_s[PW-1:DATA_W-1];

  always_comb begin
    res_o    = a_i;
    flg_o    = flg_i;
    wr_reg_o = 1'b0;
    wr_mem_o = 1'b0;
    case (op_i)
      OP_LD: begin
        res_o    = b_i;
        wr_reg_o = 1'b1;
        flg_o    = '{ovf: 1'b0, cry: 1'b0, zer: (b_i == '0), sgn: b_i[DATA_W-1]};
      end
      OP_ST: begin
        res_o    = a_i;
        wr_mem_o = !imm_i;
      end
      OP_ADD: begin
        res_o     = sum[DATA_W-1:0];
        wr_reg_o  = 1'b1;
        flg_o.cry = sum[DATA_W];
        flg_o.ovf = (a_i[DATA_W-1] == b_i[DATA_W-1]) && (sum[DATA_W-1] != a_i[DATA_W-1]);
        flg_o.zer = (sum[DATA_W-1:0] == '0);
        flg_o.sgn = sum[DATA_W-1];
      end
      OP_MUL: begin
        res_o     = prod_u[DATA_W-1:0];
        wr_reg_o  = 1'b1;
        flg_o.cry = |prod_u[PW-1:DATA_W];
        flg_o.ovf = !((&prod_hi) || !(|prod_hi));
        flg_o.zer = (prod_u[DATA_W-1:0] == '0);
        flg_o.sgn = prod_u[DATA_W-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 4,
  parameter int MEM_DEPTH = 16,
  localparam int REG_AW   = $clog2(NUM_REGS),
  localparam int MEM_AW   = $clog2(MEM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              imm_i,
  input  logic [REG_AW-1:0] dst_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [REG_AW-1:0] obs_reg_i,
  input  logic [MEM_AW-1:0] obs_addr_i,
  output logic [DATA_W-1:0] obs_reg_o,
  output logic [DATA_W-1:0] obs_mem_o,
  output flags_t            flags_o
);
  logic [DATA_W-1:0] rf_q  [NUM_REGS];
  logic [DATA_W-1:0] mem_q [MEM_DEPTH];
  flags_t            flg_q;

  logic [DATA_W-1:0] opnd, res;
  flags_t            flg_n;
  logic              wr_reg, wr_mem;

  assign opnd = imm_i ? DATA_W'(addr_i) : mem_q[addr_i];

  simd_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (op_i),
    .imm_i   (imm_i),
    .a_i     (rf_q[dst_i]),
    .b_i     (opnd),
    .flg_i   (flg_q),
    .res_o   (res),
    .flg_o   (flg_n),
    .wr_reg_o(wr_reg),
    .wr_mem_o(wr_mem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) rf_q[i] <= '0;
      for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
      flg_q <= '0;
    end else if (en_i) begin
      flg_q <= flg_n;
      if (wr_reg) rf_q[dst_i] <= res;
      if (wr_mem) mem_q[addr_i] <= res;
    end
  end

  assign obs_reg_o = rf_q[obs_reg_i];
  assign obs_mem_o = mem_q[obs_addr_i];
  assign flags_o   = flg_q;

  logic [NUM_REGS*DATA_W-1:0]  rf_flat;
  logic [MEM_DEPTH*DATA_W-1:0] mem_flat;
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_rf_flat
    assign rf_flat[g*DATA_W +: DATA_W] = rf_q[g];
  end
  for (genvar g = 0; g < MEM_DEPTH; g++) begin : g_mem_flat
    assign mem_flat[g*DATA_W +: DATA_W] = mem_q[g];
  end

  assert_masked_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(rf_flat) && $stable(mem_flat) && $stable(flg_q)));

  assert_add_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_ADD && dst_i == '0) |=> (flg_q.zer == (rf_q[0] == '0)));
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_pkg::*;
#(
  parameter int NUM_PE    = 4,
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 4,
  parameter int MEM_DEPTH = 16,
  localparam int PE_AW    = $clog2(NUM_PE),
  localparam int REG_AW   = $clog2(NUM_REGS),
  localparam int MEM_AW   = $clog2(MEM_DEPTH),
  localparam int FLG_W    = $bits(flags_t)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [5:0]              opcode_i,
  input  logic [REG_AW-1:0]       dst_i,
  input  logic [MEM_AW-1:0]       addr_i,
  input  logic [NUM_PE-1:0]       mask_i,
  output logic                    done_o,
  input  logic [PE_AW-1:0]        obs_pe_i,
  input  logic [REG_AW-1:0]       obs_reg_i,
  input  logic [MEM_AW-1:0]       obs_addr_i,
  output logic [DATA_W-1:0]       obs_reg_o,
  output logic [DATA_W-1:0]       obs_mem_o,
  output logic [NUM_PE*FLG_W-1:0] flags_o
);
  logic [NUM_PE-1:0] pe_en;
  logic [OP_W-1:0]   op;
  logic              imm;
  logic [REG_AW-1:0] dst;
  logic [MEM_AW-1:0] addr;
  logic [DATA_W-1:0] reg_rd [NUM_PE];
  logic [DATA_W-1:0] mem_rd [NUM_PE];

  simd_ctrl #(.NUM_PE(NUM_PE), .REG_AW(REG_AW), .MEM_AW(MEM_AW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .opcode_i(opcode_i),
    .dst_i   (dst_i),
    .addr_i  (addr_i),
    .mask_i  (mask_i),
    .pe_en_o (pe_en),
    .op_o    (op),
    .imm_o   (imm),
    .dst_o   (dst),
    .addr_o  (addr),
    .done_o  (done_o)
  );

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    flags_t flg;
    simd_pe #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .MEM_DEPTH(MEM_DEPTH)) u_pe (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (pe_en[p]),
      .op_i      (op),
      .imm_i     (imm),
      .dst_i     (dst),
      .addr_i    (addr),
      .obs_reg_i (obs_reg_i),
      .obs_addr_i(obs_addr_i),
      .obs_reg_o (reg_rd[p]),
      .obs_mem_o (mem_rd[p]),
      .flags_o   (flg)
    );
    assign flags_o[p*FLG_W +: FLG_W] = flg;
  end

  assign obs_reg_o = reg_rd[obs_pe_i];
  assign obs_mem_o = mem_rd[obs_pe_i];

  assert_done_timing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 2));

  assert_class_ignore_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && opcode_i[5:4] != 2'b00) |-> ##2 $stable(flags_o));
endmodule

// File: tb/simd_pe_array_test.sv
module simd_pe_array_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [5:0]  opcode = 0;
  logic [1:0]  dst = 0, obs_pe = 0, obs_reg = 0;
  logic [3:0]  addr = 0, mask = 0, obs_addr = 0;
  logic        done;
  logic [15:0] obs_reg_v, obs_mem_v, flags;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [15:0] m_reg [4][4];
  logic [15:0] m_mem [4][16];
  logic [3:0]  m_flg [4];

  simd_pe_array uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .dst_i(dst), .addr_i(addr), .mask_i(mask), .done_o(done),
    .obs_pe_i(obs_pe), .obs_reg_i(obs_reg), .obs_addr_i(obs_addr),
    .obs_reg_o(obs_reg_v), .obs_mem_o(obs_mem_v), .flags_o(flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    for (int p = 0; p < 4; p++) begin
      obs_pe = 2'(p);
      for (int r = 0; r < 4; r++) begin
        obs_reg = 2'(r);
        #1;
        chk(obs_reg_v === m_reg[p][r], req, $sformatf("pe%0d reg%0d", p, r), obs_reg_v, m_reg[p][r]);
      end
      for (int a = 0; a < 16; a++) begin
        obs_addr = 4'(a);
        #1;
        chk(obs_mem_v === m_mem[p][a], req, $sformatf("pe%0d mem%0d", p, a), obs_mem_v, m_mem[p][a]);
      end
      // R11 flag lane layout {ovf,cry,zer,sgn}
      chk(flags[p*4 +: 4] === m_flg[p], req, $sformatf("pe%0d flags", p), flags[p*4 +: 4], m_flg[p]);
    end
  endtask

  task automatic model(input logic [1:0] cls, input logic im, input logic [2:0] op,
                       input logic [1:0] d, input logic [3:0] ad, input logic [3:0] mk);
    if (cls != 2'b00) return;
    for (int p = 0; p < 4; p++) begin
      if (mk[p]) begin
        logic [15:0] a, b, r;
        logic [16:0] s;
        logic [31:0] pu;
        int sp;
        a = m_reg[p][d];
        b = im ? {12'd0, ad} : m_mem[p][ad];
        case (op)
          3'd0: begin m_reg[p][d] = b; m_flg[p] = {2'b00, b == 0, b[15]}; end
          3'd1: if (!im) m_mem[p][ad] = a;
          3'd2: begin
            s = {1'b0, a} + {1'b0, b};
            r = s[15:0];
            m_reg[p][d] = r;
            m_flg[p] = {(a[15] == b[15]) && (r[15] != a[15]), s[16], r == 0, r[15]};
          end
          3'd3: begin
            pu = {16'd0, a} * {16'd0, b};
            sp = int'($signed(a)) * int'($signed(b));
            r = pu[15:0];
            m_reg[p][d] = r;
            m_flg[p] = {(sp > 32767) || (sp < -32768), pu[31:16] != 0, r == 0, r[15]};
          end
          default: ;
        endcase
      end
    end
  endtask

  task automatic issue(input logic [1:0] cls, input logic im, input logic [2:0] op,
                       input logic [1:0] d, input logic [3:0] ad, input logic [3:0] mk,
                       input string req);
    @(negedge clk);
    start = 1; opcode = {cls, im, op}; dst = d; addr = ad; mask = mk;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    chk(done === 1'b1, "R8", "done high after commit", done, 1);
    model(cls, im, op, d, ad, mk);
    compare_all(req);
    @(negedge clk);
    chk(done === 1'b0, "R8", "done single cycle", done, 0);
  endtask

  function automatic string op_req(input logic [2:0] op, input logic im);
    case (op)
      3'd0: return im ? "R7" : "R3";
      3'd1: return im ? "R7" : "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 4; r++) m_reg[p][r] = 0;
      for (int a = 0; a < 16; a++) m_mem[p][a] = 0;
      m_flg[p] = 0;
    end
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R9", "done in reset", done, 0);
    rst_n = 1;
    @(negedge clk);
    compare_all("R9");

    // per-PE immediate loads, one PE at a time (R2, R7)
    for (int p = 0; p < 4; p++) begin
      issue(2'b00, 1, 3'd0, 2'(p), 4'(p * 3 + 2), 4'(1 << p), "R2");
      issue(2'b00, 0, 3'd1, 2'(p), 4'(p + 8), 4'hF, "R4");
    end

    // ADD doubling to reach carry and overflow (R5)
    issue(2'b00, 1, 3'd0, 2'd0, 4'd15, 4'hF, "R3");
    for (int i = 0; i < 14; i++) begin
      issue(2'b00, 0, 3'd1, 2'd0, 4'd15, 4'hF, "R4");
      issue(2'b00, 0, 3'd2, 2'd0, 4'd15, 4'hF, "R5");
    end
    // MUL square with overflow and carry (R6)
    issue(2'b00, 1, 3'd0, 2'd1, 4'd13, 4'hF, "R3");
    for (int i = 0; i < 4; i++) begin
      issue(2'b00, 0, 3'd1, 2'd1, 4'd14, 4'hF, "R4");
      issue(2'b00, 0, 3'd3, 2'd1, 4'd14, 4'hF, "R6");
    end
    issue(2'b00, 1, 3'd3, 2'd1, 4'd0, 4'b0101, "R6");

    // immediate store writes nothing (R7)
    issue(2'b00, 1, 3'd1, 2'd0, 4'd8, 4'hF, "R7");

    // sweep over ops, modes, masks, registers and addresses
    for (int i = 0; i < 256; i++) begin
      logic [7:0] iv;
      iv = 8'(i);
      issue(2'b00, iv[3], iv[2:0], 2'((i * 3) % 4), 4'((i * 5) % 16), iv[7:4],
            iv[7:4] != 4'hF ? "R2" : op_req(iv[2:0], iv[3]));
    end

    // non-compute classes ignored (R1)
    for (int c = 1; c < 4; c++)
      for (int op = 0; op < 4; op++)
        issue(2'(c), 0, 3'(op), 2'(op), 4'(c + op), 4'hF, "R1");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule